// File: doc/BRIEF.md
# Dual-Threshold Watchdog Timer

This block is a watchdog built around a single up-counter that runs on the peripheral clock. Software programs two timeout codes, one for an early-warning interrupt and one for a system reset request. Each code selects a power-of-two number of cycles, and each of the two outputs has its own enable. While either output is enabled the counter runs. Software restarts the count by writing the service register. If software stops servicing, the interrupt threshold is reached first, and a handler can still recover. If nothing recovers, the reset threshold is reached and a one-cycle reset request is issued.

A sticky flag records that the watchdog requested a reset. That flag is cleared only by power-on reset or by software, so boot code can still read it after the system reset that the watchdog itself caused. The interrupt is a level output backed by a flag that software clears by writing one to it.

Top module: `dual_wdog`

## Requirements
- R1: After power-on reset, `irq` and `rst_req` are low and the control register (address 0) reads 0.
- R2: A period code n (0..15) selects a timeout of 2^(CNT_W-1-n) clock cycles. The output concerned rises that many rising edges after the edge that started the count, which is either an enabling control write or a service write.
- R3: While both enables are 0 the counter holds at zero and neither output asserts. Enabling later starts a full period from zero.
- R4: Any write to address 1 (service) restarts the count from zero, so the next timeout is a full period after the service edge.
- R5: A service write on the edge where a threshold would be crossed suppresses that crossing, and neither output asserts at that edge.
- R6: `irq` is a level that stays high until software writes 1 to control bit 10. Bit 10 reads back the interrupt flag.
- R7: After it is cleared, `irq` is not raised again until the count has been restarted and crosses the threshold again.
- R8: When the reset output is enabled, the interrupt is raised only if the interrupt code is strictly greater than the reset code (a shorter period). Otherwise the reset request wins and no interrupt is raised.
- R9: `rst_req` is a single-cycle pulse, issued once per restart of the count.
- R10: Control bit 11 (reset flag) is set together with `rst_req`. The `rst` input does not clear it. `por` or writing 1 to bit 11 does.
- R11: With only the interrupt enabled, the interrupt fires at its own period for any code.
- R12: Control register layout: bits [3:0] interrupt code, [7:4] reset code, [8] interrupt enable, [9] reset enable, [10] interrupt flag (write 1 to clear), [11] reset flag (write 1 to clear). All other bits read 0, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| rst | input | 1 | System reset, synchronous, active high; keeps the reset flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 service) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Early-warning interrupt level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach from the ports is a service write that lands on exactly the edge where a threshold would be crossed. The bench counts edges from the enabling write and issues the service write on the last cycle before the crossing, then checks that no pulse appears and that the next pulse arrives a full period after the service. The race between the two thresholds is covered by random code pairs, including equal codes, and each measured arrival time is compared against periods computed in the bench.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CODE_W = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    // Control register bit positions
    localparam int B_IRQ_CODE = 0;
    localparam int B_RST_CODE = 4;
    localparam int B_IRQ_EN   = 8;
    localparam int B_RST_EN   = 9;
    localparam int B_IRQ_FLAG = 10;
    localparam int B_RST_FLAG = 11;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_SVC  = 2'd1;

    typedef enum int {SRC_IRQ = 0, SRC_RST = 1} wdg_src_e;
    localparam int N_SRC = 2;

    typedef struct packed {
        logic [CODE_W-1:0] rst_code;
        logic [CODE_W-1:0] irq_code;
        logic              rst_en;
        logic              irq_en;
    } wdg_cfg_t;

    // Counter bit whose first setting marks the timeout for a code
    function automatic int thr_bit(input logic [CODE_W-1:0] code, input int cnt_w);
        return cnt_w - 1 - int'(code);
    endfunction

    // Interrupt may fire only when its period is shorter than the reset period
    function automatic logic irq_allowed(input wdg_cfg_t c);
        return c.irq_en && (!c.rst_en || (c.irq_code > c.rst_code));
    endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              set_irq,
    input  logic              set_rst,
    output logic [DATA_W-1:0] rd_data,
    output wdg_cfg_t          cfg,
    output logic              service,
    output logic              irq_flag,
    output logic              rst_flag
);
    logic ctrl_wr;
    logic unused_hi;

    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign service   = wr_en && (wr_addr == A_SVC);
    assign unused_hi = ^wr_data[DATA_W-1:B_RST_FLAG+1];

    always_ff @(posedge clk) begin
        if (por || rst) begin
            cfg <= '0;
        end else if (ctrl_wr) begin
            cfg.irq_code <= wr_data[B_IRQ_CODE +: CODE_W];
            cfg.rst_code <= wr_data[B_RST_CODE +: CODE_W];
            cfg.irq_en   <= wr_data[B_IRQ_EN];
            cfg.rst_en   <= wr_data[B_RST_EN];
        end
    end

    // Interrupt flag: set wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (por || rst)                          irq_flag <= 1'b0;
        else if (set_irq)                        irq_flag <= 1'b1;
        else if (ctrl_wr && wr_data[B_IRQ_FLAG]) irq_flag <= 1'b0;
    end

    // Reset cause flag: survives the system reset it causes
    always_ff @(posedge clk) begin
        if (por)                                 rst_flag <= 1'b0;
        else if (set_rst)                        rst_flag <= 1'b1;
        else if (ctrl_wr && wr_data[B_RST_FLAG]) rst_flag <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[B_IRQ_CODE +: CODE_W] = cfg.irq_code;
            rd_data[B_RST_CODE +: CODE_W] = cfg.rst_code;
            rd_data[B_IRQ_EN]             = cfg.irq_en;
            rd_data[B_RST_EN]             = cfg.rst_en;
            rd_data[B_IRQ_FLAG]           = irq_flag;
            rd_data[B_RST_FLAG]           = rst_flag;
        end
    end

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (por)
        (rst && rst_flag && !ctrl_wr) |=> rst_flag);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             service,
    output logic [CNT_W-1:0] cnt,
    output logic             step
);
    assign step = run && !service;

    always_ff @(posedge clk) begin
        if (rst || !step) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
    assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
        service |=> (cnt == '0));
endmodule

// File: rtl/wdg_cross.sv
module wdg_cross
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              step,
    input  logic              rearm,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    logic [CNT_W-1:0] bit_mask;
    logic [CNT_W-1:0] low_mask;
    logic             at_edge;
    logic             armed;

    always_comb begin
        bit_mask = {{(CNT_W-1){1'b0}}, 1'b1} << thr_bit(code, CNT_W);
        low_mask = bit_mask - 1'b1;
    end

    // The selected bit is about to turn on with this increment
    assign at_edge = step && ((cnt & low_mask) == low_mask) && ((cnt & bit_mask) == '0);
    assign hit     = at_edge && armed;

    always_ff @(posedge clk) begin
        if (rst || rearm) armed <= 1'b1;
        else if (at_edge) armed <= 1'b0;
    end

    assert_single_hit_R7: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);
endmodule

// File: rtl/dual_wdog.sv
module dual_wdog
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32   // must be at least 16 so that every code is valid
) (
    input  logic              clk,
    input  logic              por,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              rst_req
);
    wdg_cfg_t          cfg;
    logic              service;
    logic              run;
    logic              step;
    logic              any_rst;
    logic              irq_ev;
    logic              rst_ev;
    logic              irq_flag;
    logic              rst_flag;
    logic              rst_req_q;
    logic [CNT_W-1:0]  cnt;
    logic [N_SRC-1:0]  hit;
    logic [CODE_W-1:0] src_code [N_SRC];

    assign any_rst           = por || rst;
    assign run               = cfg.irq_en || cfg.rst_en;
    assign src_code[SRC_IRQ] = cfg.irq_code;
    assign src_code[SRC_RST] = cfg.rst_code;

    wdg_regs i_regs (
        .clk      (clk),
        .por      (por),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .set_irq  (irq_ev),
        .set_rst  (rst_ev),
        .rd_data  (rd_data),
        .cfg      (cfg),
        .service  (service),
        .irq_flag (irq_flag),
        .rst_flag (rst_flag)
    );

    wdg_counter #(.CNT_W(CNT_W)) i_counter (
        .clk     (clk),
        .rst     (any_rst),
        .run     (run),
        .service (service),
        .cnt     (cnt),
        .step    (step)
    );

    for (genvar s = 0; s < N_SRC; s++) begin : g_thr
        wdg_cross #(.CNT_W(CNT_W)) i_cross (
            .clk   (clk),
            .rst   (any_rst),
            .cnt   (cnt),
            .step  (step),
            .rearm (service || !run),
            .code  (src_code[s]),
            .hit   (hit[s])
        );
    end

    assign irq_ev = hit[SRC_IRQ] && irq_allowed(cfg);
    assign rst_ev = hit[SRC_RST] && cfg.rst_en;

    always_ff @(posedge clk) begin
        if (any_rst) rst_req_q <= 1'b0;
        else         rst_req_q <= rst_ev;
    end

    assign rst_req = rst_req_q;
    assign irq     = irq_flag;

    assert_pulse_R9: assert property (@(posedge clk) disable iff (any_rst)
        rst_req |=> !rst_req);
    assert_flag_with_req_R10: assert property (@(posedge clk) disable iff (any_rst)
        rst_req |-> rst_flag);
    assert_irq_order_R8: assert property (@(posedge clk) disable iff (any_rst)
        $rose(irq) |-> (!$past(cfg.rst_en) || ($past(cfg.irq_code) > $past(cfg.rst_code))));
    assert_service_wins_R5: assert property (@(posedge clk) disable iff (any_rst)
        service |=> (!rst_req && !$rose(irq)));
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (any_rst)
        (!run && !$past(run)) |-> !rst_req);
endmodule

// File: tb/test_dual_wdog.sv
module test_dual_wdog;
    localparam int CW = 18;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dual_wdog #(.CNT_W(CW)) i_dual_wdog (
        .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .rst_req(rst_req)
    );

    always #2 clk = ~clk;

    function automatic int period(input int code);
        return 1 << (CW - 1 - code);
    endfunction

    function automatic logic [31:0] ctrl(input int ic, input int rc, input bit ie,
                                         input bit re, input bit c_irq, input bit c_rst);
        return {20'd0, c_rst, c_irq, re, ie, rc[3:0], ic[3:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input bit is_por);
        @(negedge clk);
        if (is_por) por = 1'b1; else rst = 1'b1;
        repeat (2) @(negedge clk);
        por = 1'b0; rst = 1'b0;
    endtask

    task automatic window(input int limit, output int t_irq, output int t_rst, output int n_rst);
        t_irq = -1; t_rst = -1; n_rst = 0;
        for (int m = 1; m <= limit; m++) begin
            @(negedge clk);
            if (irq && t_irq < 0) t_irq = m;
            if (rst_req) begin
                n_rst++;
                if (t_rst < 0) t_rst = m;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int ti, tr, nr;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rst_req", int'(rst_req), 0);
        rd(2'd0, d); chk("R1 ctrl", int'(d), 0);

        // R12: layout, unused bits, other addresses
        wr(2'd0, 32'hFFFF_F3A5);
        rd(2'd0, d); chk("R12 ctrl readback", int'(d), 32'h3A5);
        rd(2'd1, d); chk("R12 service reads zero", int'(d), 0);
        rd(2'd2, d); chk("R12 spare address", int'(d), 0);
        wr(2'd0, 32'd0);

        // R3: disabled counter stays quiet, enabling starts from zero
        wr(2'd0, ctrl(15, 15, 0, 0, 0, 0));
        window(100, ti, tr, nr);
        chk("R3 no irq while disabled", ti, -1);
        chk("R3 no rst_req while disabled", nr, 0);
        wr(2'd0, ctrl(15, 0, 1, 0, 0, 0));
        window(10, ti, tr, nr);
        chk("R3 R11 period from enable", ti, period(15));

        // R6, R7: level irq, clear, no re-raise without restart
        repeat (20) @(negedge clk);
        chk("R6 irq holds", int'(irq), 1);
        rd(2'd0, d); chk("R6 flag bit10", int'(d[10]), 1);
        wr(2'd0, ctrl(15, 0, 1, 0, 1, 0));
        chk("R6 irq cleared", int'(irq), 0);
        window(200, ti, tr, nr);
        chk("R7 no re-raise", ti, -1);
        wr(2'd1, 32'd0);
        window(10, ti, tr, nr);
        chk("R7 re-raise after service", ti, period(15));

        // R4: service restarts the count
        pulse(0);
        wr(2'd0, ctrl(13, 0, 1, 0, 0, 0));
        repeat (9) @(negedge clk);
        wr(2'd1, 32'd0);
        chk("R4 irq low after service", int'(irq), 0);
        window(40, ti, tr, nr);
        chk("R4 full period after service", ti, period(13));

        // R5: service on the crossing edge suppresses the reset request
        pulse(0);
        wr(2'd0, ctrl(0, 14, 0, 1, 0, 0));
        repeat (6) @(negedge clk);
        wr(2'd1, 32'd0);
        chk("R5 no rst_req at suppressed edge", int'(rst_req), 0);
        window(20, ti, tr, nr);
        chk("R5 next rst_req a full period later", tr, period(14));
        chk("R9 single pulse", nr, 1);

        // R10: flag survives system reset, cleared by por
        pulse(0);
        rd(2'd0, d); chk("R10 flag after system reset", int'(d[11]), 1);
        pulse(1);
        rd(2'd0, d); chk("R10 flag cleared by por", int'(d[11]), 0);

        // Random code pairs: R2, R8, R9, R10, R11
        for (int it = 0; it < 30; it++) begin
            int ic, rc, ei, er;
            bit ie, re;
            pulse(0);
            ic = 10 + int'($urandom % 6);
            rc = (it % 5 == 0) ? ic : 10 + int'($urandom % 6);
            ie = $urandom % 2 == 1;
            re = $urandom % 2 == 1;
            wr(2'd0, ctrl(ic, rc, ie, re, 1, 1));
            window(300, ti, tr, nr);
            ei = (ie && (!re || ic > rc)) ? period(ic) : -1;
            er = re ? period(rc) : -1;
            chk("R2 R8 R11 irq time", ti, ei);
            chk("R2 reset time", tr, er);
            chk("R9 pulse count", nr, re ? 1 : 0);
            rd(2'd0, d); chk("R10 flag with request", int'(d[11]), re ? 1 : 0);
            if (re) begin
                wr(2'd0, ctrl(0, 0, 0, 0, 0, 1));
                rd(2'd0, d); chk("R10 flag write-one clear", int'(d[11]), 0);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule